// File: doc/BRIEF.md
# Truth-Table Programmable Bitwise Logic Unit

This block combines two operand words bit by bit using any one of the sixteen Boolean functions of two inputs. The function is not named by an opcode. It is given directly as a 4-bit truth table, `func_tt`. For each bit position the operand pair `{op_a[i], op_b[i]}` forms an index from 0 to 3, and that index picks one bit of `func_tt`. Each bit position therefore needs only one 4-to-1 selector, and the same structure covers AND, OR, XOR, the inverted forms, pass-through, the constants and the inhibition and implication functions.

The unit is purely combinational and its width is a parameter. An enable input gates the whole output word. When the enable is low, the output is all zeros whatever the operands and the function code. A datapath typically drives `func_tt` straight from a decoded instruction field. It can build masks by setting bits (OR), clear bits (AND) or toggle bits (XOR) without a separate decode stage.

Top module: `truth_logic_unit`

## Requirements
- R1: With `unit_en` = 1, every result bit i equals `func_tt[{op_a[i], op_b[i]}]`, where `op_a[i]` is the upper index bit. Index 0 means a=0,b=0; index 1 means a=0,b=1; index 2 means a=1,b=0; index 3 means a=1,b=1.
- R2: Code 4'b1110 gives bitwise OR. For example, 16'h001E OR 16'h0098 gives 16'h009E.
- R3: Code 4'b1000 gives bitwise AND. For example, 16'h001E AND 16'h0098 gives 16'h0018.
- R4: Code 4'b0111 gives bitwise NAND.
- R5: Code 4'b0000 gives all zeros and code 4'b1111 gives all ones, whatever the operands.
- R6: Code 4'b1100 passes `op_a` through unchanged. Code 4'b1010 passes `op_b` through unchanged.
- R7: With `unit_en` = 0 the result is all zeros for every operand and code value.
- R8: The result follows its inputs with no clock and no stored state. A change on any input shows at the output before any clock edge.
- R9: Each bit position depends only on its own operand bits. A single set operand bit affects only the matching result bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand; upper bit of each slice's index |
| op_b | input | WIDTH | Second operand; lower bit of each slice's index |
| func_tt | input | 4 | Truth table of the function, bit k is the output for index k |
| unit_en | input | 1 | 1 enables the unit, 0 forces the result to zero |
| result | output | WIDTH | Bitwise function result |

## Verification
The bench targets the index ordering first. Pass-A and pass-B codes (4'b1100, 4'b1010) and the asymmetric inhibition code 4'b0100 give different results if the two operand bits are swapped on the selector, so a swapped design would return B for A and A&~B as B&~A. A walking single bit on each operand catches a slice wired to a neighbouring position, which would show the bit at the wrong place in the result. All sixteen codes are run against a minterm-sum model. Disabled cases use all-ones operands and all-ones code, so an enable that gated only some bits, or was ignored, leaves ones at the output.

// File: rtl/tt_logic_pkg.sv
package tt_logic_pkg;

    typedef logic [3:0] tt_code_t;

    // Truth-table bit k is the output for index k = {a, b}
    localparam tt_code_t TT_ZERO   = 4'b0000;
    localparam tt_code_t TT_AND    = 4'b1000;
    localparam tt_code_t TT_OR     = 4'b1110;
    localparam tt_code_t TT_NAND   = 4'b0111;
    localparam tt_code_t TT_PASS_A = 4'b1100;
    localparam tt_code_t TT_PASS_B = 4'b1010;
    localparam tt_code_t TT_ONES   = 4'b1111;

endpackage

// File: rtl/tt_bit_slice.sv
module tt_bit_slice
    import tt_logic_pkg::*;
(
    input  logic     a_bit,
    input  logic     b_bit,
    input  tt_code_t table_in,
    output logic     y_bit
);

    logic [1:0] sel_d;

    // Operand bits act as selector lines; a is the upper select bit
    always_comb begin
        sel_d = {a_bit, b_bit};
        case (sel_d)
            2'd0:    y_bit = table_in[0];
            2'd1:    y_bit = table_in[1];
            2'd2:    y_bit = table_in[2];
            default: y_bit = table_in[3];
        endcase
    end

endmodule

// File: rtl/tt_output_gate.sv
module tt_output_gate #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] raw_in,
    input  logic             gate_en,
    output logic [WIDTH-1:0] gated_out
);

    always_comb begin
        gated_out = gate_en ? raw_in : '0;
    end

endmodule

// File: rtl/truth_logic_unit.sv
module truth_logic_unit
    import tt_logic_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       func_tt,
    input  logic             unit_en,
    output logic [WIDTH-1:0] result
);

    localparam int LAST_BIT = WIDTH - 1;

    tt_code_t         code_d;
    logic [LAST_BIT:0] slice_d;

    always_comb begin
        code_d = tt_code_t'(func_tt);
    end

    // One identical selector per bit position
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        tt_bit_slice u_slice (
            .a_bit    (op_a[gi]),
            .b_bit    (op_b[gi]),
            .table_in (code_d),
            .y_bit    (slice_d[gi])
        );
    end

    tt_output_gate #(.WIDTH(WIDTH)) u_gate (
        .raw_in    (slice_d),
        .gate_en   (unit_en),
        .gated_out (result)
    );

endmodule

// File: rtl/truth_logic_unit_chk.sv
module truth_logic_unit_chk
    import tt_logic_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       func_tt,
    input logic             unit_en,
    input logic [WIDTH-1:0] result
);

    always_comb begin
        if (!unit_en)
            assert_disabled_zero_R7: assert (result == '0);
        if (unit_en && func_tt == TT_ZERO)
            assert_const_zero_R5: assert (result == '0);
        if (unit_en && func_tt == TT_ONES)
            assert_const_ones_R5: assert (&result);
        if (unit_en && func_tt == TT_OR)
            assert_or_func_R2: assert (result == (op_a | op_b));
        if (unit_en && func_tt == TT_AND)
            assert_and_func_R3: assert (result == (op_a & op_b));
        if (unit_en && func_tt == TT_NAND)
            assert_nand_func_R4: assert (result == ~(op_a & op_b));
        if (unit_en && func_tt == TT_PASS_A)
            assert_pass_a_R6: assert (result == op_a);
        if (unit_en && func_tt == TT_PASS_B)
            assert_pass_b_R6: assert (result == op_b);
    end

endmodule

bind truth_logic_unit truth_logic_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .func_tt (func_tt),
    .unit_en (unit_en),
    .result  (result)
);

// File: tb/tb_truth_logic_unit.sv
module tb_truth_logic_unit;

    localparam int W = 16;
    localparam int NV = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   func_tt = '0;
    logic         unit_en = 1'b0;
    logic [W-1:0] result;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    truth_logic_unit #(.WIDTH(W)) dut (
        .op_a    (op_a),
        .op_b    (op_b),
        .func_tt (func_tt),
        .unit_en (unit_en),
        .result  (result)
    );

    // {en, code, a, b, expected}
    localparam logic [52:0] VEC [NV] = '{
        {1'b1, 4'b1110, 16'h001E, 16'h0098, 16'h009E},  // R2 OR
        {1'b1, 4'b1000, 16'h001E, 16'h0098, 16'h0018},  // R3 AND
        {1'b1, 4'b0111, 16'hF0F0, 16'hFF00, 16'h0FFF},  // R4 NAND
        {1'b1, 4'b0000, 16'hFFFF, 16'hFFFF, 16'h0000},  // R5 zero
        {1'b1, 4'b1111, 16'h0000, 16'h0000, 16'hFFFF},  // R5 ones
        {1'b1, 4'b1100, 16'h1234, 16'hABCD, 16'h1234},  // R6 pass a
        {1'b1, 4'b1010, 16'h1234, 16'hABCD, 16'hABCD},  // R6 pass b
        {1'b1, 4'b0110, 16'hF0F0, 16'hFF00, 16'h0FF0},  // R1 XOR
        {1'b1, 4'b1001, 16'hF0F0, 16'hFF00, 16'hF00F},  // R1 XNOR
        {1'b1, 4'b0100, 16'hF0F0, 16'hFF00, 16'h00F0},  // R1 a and not b
        {1'b1, 4'b0001, 16'hF0F0, 16'hFF00, 16'h000F},  // R1 NOR
        {1'b0, 4'b1110, 16'hFFFF, 16'hFFFF, 16'h0000},  // R7 disabled
        {1'b0, 4'b1111, 16'h0000, 16'h0000, 16'h0000}   // R7 disabled
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic en, input logic [3:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        unit_en = en;
        func_tt = fn;
        op_a = a;
        op_b = b;
        #1;
    endtask

    function automatic logic [W-1:0] model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        return (~a & ~b & {W{c[0]}}) | (~a & b & {W{c[1]}}) |
               (a & ~b & {W{c[2]}}) | (a & b & {W{c[3]}});
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset period: unit held disabled, output must read zero (R7)
        op_a = '1;
        op_b = '1;
        func_tt = 4'b1111;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset idle", result, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][52], VEC[i][51:48], VEC[i][47:32], VEC[i][31:16]);
            check($sformatf("R1 vector %0d", i), result, VEC[i][15:0]);
        end

        // All sixteen codes against a minterm-sum model (R1)
        for (int c = 0; c < 16; c++) begin
            apply(1'b1, 4'(c), 16'h3C96, 16'h5A0F);
            check($sformatf("R1 code %0d", c), result, model(4'(c), 16'h3C96, 16'h5A0F));
        end

        // Walking bit through each slice (R9)
        for (int i = 0; i < W; i++) begin
            apply(1'b1, 4'b1100, W'(1) << i, '0);
            check($sformatf("R9 pass a bit %0d", i), result, W'(1) << i);
            apply(1'b1, 4'b0110, '0, W'(1) << i);
            check($sformatf("R9 xor b bit %0d", i), result, W'(1) << i);
        end

        // Output follows inputs between clock edges (R8)
        @(posedge clk);
        #0.5;
        unit_en = 1'b1;
        func_tt = 4'b1110;
        op_a = 16'h00F0;
        op_b = 16'h0F00;
        #0.5;
        check("R8 mid-cycle update", result, 16'h0FF0);
        op_b = 16'hF000;
        #0.5;
        check("R8 second update", result, 16'hF0F0);
        unit_en = 1'b0;
        #0.5;
        check("R7 enable drop", result, 16'h0000);

        // Disabled under every code (R7)
        for (int c = 0; c < 16; c++) begin
            apply(1'b0, 4'(c), 16'hFFFF, 16'h0000);
            check($sformatf("R7 disabled code %0d", c), result, '0);
        end

        finish_run();
    end

endmodule